// File: doc/BRIEF.md
# Four-Entry Sample Queue with Sticky Error Flags

This block buffers up to four 12-bit samples between a converter and a register-mapped reader. Samples come in from two sources. One is the converter's write port, which is taken only while the block runs. The other is a software write to the data register, which puts a dummy sample into the queue. Software pops samples by reading the data register, and it sees the queue's state through a status word and five status pins.

Two error conditions are sticky. A push into a full queue sets overflow. From then on the write pointer does not move, so no further sample can enter. A pop from an empty queue sets underflow. From then on the read pointer does not move, and every data read returns the last sample that was popped. Only the flush command clears these flags. Flush also rewinds both pointers and empties the queue.

A two-bit command register selects the mode: disable, enable or flush. After writing flush, software waits two cycles and then writes enable or disable.

Top module: `sample_fifo`

## Requirements
- R1: After reset the status reads empty=1 with all other flags 0, the command reads 0 (disable), and a data read returns 0.
- R2: Data reads return samples oldest first. The queue holds at most 4 samples of 12 bits each.
- R3: Full is 1 at exactly 4 entries, almost-full is 1 at exactly 3 entries, and empty is 1 at 0 entries. A read with select 1 returns the status word: overflow in bit 4, underflow in bit 3, full in bit 2, almost-full in bit 1 and empty in bit 0, with all other bits 0.
- R4: A push while the queue is full is dropped and sets overflow. While overflow is set, no push is accepted, even after pops have made room.
- R5: A data read while the queue is empty returns the last popped sample and sets underflow. While underflow is set, the read pointer does not move and data reads keep returning that sample, even when entries are present.
- R6: Overflow and underflow stay set until a flush. In every cycle the registered command is flush (3), the block clears both pointers, the occupancy and both flags.
- R7: A write with select 2 loads bits 1:0 into the command register, and a read with select 2 returns the stored value. The codes are 0 for disable, 1 for enable and 3 for flush. Code 2 behaves as disable.
- R8: A converter sample (valid high) is accepted only while the command is enable. In any other mode it has no effect.
- R9: A write with select 0 pushes its low 12 bits as a dummy sample while the command is anything other than flush. The block takes at most one push per cycle. When an accepted converter sample and a dummy write arrive together, the converter sample is queued and the dummy is discarded.
- R10: A read with select 3 returns 0. Only a read with select 0 pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 12 | Converter sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a pop when select is 0) |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 command, 3 unused |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data, combinational from select and state |
| fifo_empty | output | 1 | No entries |
| fifo_afull | output | 1 | Exactly 3 entries |
| fifo_full | output | 1 | 4 entries |
| fifo_ovf | output | 1 | Sticky overflow |
| fifo_unf | output | 1 | Sticky underflow |

## Verification
The bench targets the following corner cases:
- A pop after an overflow. A design that let the write pointer move again would accept the next push and corrupt the order.
- New data arriving during an underflow. A design that unfroze the read pointer would return fresh samples instead of the replayed one.
- Simultaneous push and pop at the full and empty boundaries, where a wrong occupancy update shows up as a misplaced almost-full or full flag.
- The reserved command code and dummy writes during flush. A wrongly decoded command would either queue samples or keep stale flags.

A long pseudo-random sweep alternates between push-heavy and pop-heavy phases and inserts occasional command changes. A reference model computed in the bench checks the read data and status word in every cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    CMD_OFF   = 2'd0,
    CMD_RUN   = 2'd1,
    CMD_RSV   = 2'd2,
    CMD_FLUSH = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // Field order fixes the status word layout: ovf is bit 4, empty is bit 0.
  typedef struct packed {
    logic ovf;
    logic unf;
    logic full;
    logic afull;
    logic empty;
  } stat_t;

  localparam int STAT_W = 5;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          conv_req,
  input  logic          dummy_req,
  input  logic          pop_req,
  output logic          do_push,
  output logic          do_pop,
  output logic          sel_conv,
  output logic          replay,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output stat_t         stat
);
  localparam logic [CW-1:0] CNT_FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_AFULL = CW'(DEPTH - 1);
  localparam logic [PW-1:0] PTR_LAST  = PW'(DEPTH - 1);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          state_en;
  logic          push_req, is_full, is_empty, ovf_set, unf_set;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // Converter has priority for the single write slot per cycle.
  assign push_req = conv_req | dummy_req;
  assign sel_conv = conv_req;
  assign is_full  = (cnt_q == CNT_FULL);
  assign is_empty = (cnt_q == '0);
  assign replay   = is_empty | unf_q;

  assign do_pop   = ~flush & pop_req & ~replay;
  assign unf_set  = ~flush & pop_req & replay;
  assign do_push  = ~flush & push_req & ~ovf_q & ~is_full;
  assign ovf_set  = ~flush & push_req & ~ovf_q & is_full;

  assign state_en = flush | do_push | do_pop | ovf_set | unf_set;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      if (ovf_set) ovf_d = 1'b1;
      if (unf_set) unf_d = 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (state_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign wr_ptr     = wr_q;
  assign rd_ptr     = rd_q;
  assign stat.ovf   = ovf_q;
  assign stat.unf   = unf_q;
  assign stat.full  = is_full;
  assign stat.afull = (cnt_q == CNT_AFULL);
  assign stat.empty = is_empty;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 12,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wr_ptr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] rd_ptr,
  input  logic          replay,
  output logic [DW-1:0] rd_sample
);
  logic [DW-1:0] ent [DEPTH];
  logic [DW-1:0] last_q, last_d;
  logic [DW-1:0] head;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          ent_we;
    logic [DW-1:0] ent_q;
    assign ent_we = we & (wr_ptr == PW'(g));
    always_ff @(posedge clk) begin
      if (ent_we) ent_q <= wdata;
    end
    assign ent[g] = ent_q;
  end

  assign head = ent[rd_ptr];

  always_comb begin
    last_d = last_q;
    if (re) last_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  last_q <= '0;
    else if (re) last_q <= last_d;
  end

  assign rd_sample = replay ? last_q : head;
endmodule

// File: rtl/sfifo_regif.sv
module sfifo_regif
  import sfifo_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  stat_t         stat,
  input  logic [DW-1:0] rd_sample,
  output cmd_e          cmd,
  output logic          flush,
  output logic          run,
  output logic          dummy_push,
  output logic          pop_req,
  output logic [DW-1:0] reg_rdata
);
  sel_e sel;
  cmd_e cmd_q, cmd_d;
  logic cmd_we;

  assign sel    = sel_e'(reg_sel);
  assign cmd_we = reg_wr & (sel == SEL_CMD);

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_we) cmd_d = cmd_e'(reg_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= CMD_OFF;
    else if (cmd_we) cmd_q <= cmd_d;
  end

  assign cmd        = cmd_q;
  assign flush      = (cmd_q == CMD_FLUSH);
  assign run        = (cmd_q == CMD_RUN);
  assign dummy_push = reg_wr & (sel == SEL_DATA) & ~flush;
  assign pop_req    = reg_rd & (sel == SEL_DATA);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_DATA: reg_rdata = rd_sample;
      SEL_STAT: reg_rdata[STAT_W-1:0] = stat;
      SEL_CMD:  reg_rdata[1:0] = cmd_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          fifo_empty,
  output logic          fifo_afull,
  output logic          fifo_full,
  output logic          fifo_ovf,
  output logic          fifo_unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_n_i;
  cmd_e          cmd_q;
  logic          flush, run, dummy_push, pop_req;
  logic          do_push, do_pop, sel_conv, replay;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] push_data, rd_sample;
  stat_t         stat;

  sfifo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sfifo_regif #(.DW(DW)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .stat       (stat),
    .rd_sample  (rd_sample),
    .cmd        (cmd_q),
    .flush      (flush),
    .run        (run),
    .dummy_push (dummy_push),
    .pop_req    (pop_req),
    .reg_rdata  (reg_rdata)
  );

  sfifo_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .flush     (flush),
    .conv_req  (smp_valid & run),
    .dummy_req (dummy_push),
    .pop_req   (pop_req),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .sel_conv  (sel_conv),
    .replay    (replay),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .stat      (stat)
  );

  assign push_data = sel_conv ? smp_data : reg_wdata;

  sfifo_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .we        (do_push),
    .wr_ptr    (wr_ptr),
    .wdata     (push_data),
    .re        (do_pop),
    .rd_ptr    (rd_ptr),
    .replay    (replay),
    .rd_sample (rd_sample)
  );

  assign fifo_empty = stat.empty;
  assign fifo_afull = stat.afull;
  assign fifo_full  = stat.full;
  assign fifo_ovf   = stat.ovf;
  assign fifo_unf   = stat.unf;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd,
  input logic          empty,
  input logic          afull,
  input logic          full,
  input logic          ovf,
  input logic          unf,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          reg_rd,
  input logic [1:0]    reg_sel
);
  p_full_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!afull && !empty));

  p_afull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    afull |-> (!full && !empty));

  p_wr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cmd != 2'd3) |=> $stable(wr_ptr));

  p_rd_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && cmd != 2'd3) |=> $stable(rd_ptr));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd0 && empty && cmd != 2'd3) |=> unf);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cmd != 2'd3) |=> ovf);

  p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && cmd != 2'd3) |=> unf);

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |=> (empty && !ovf && !unf && wr_ptr == '0 && rd_ptr == '0));
endmodule

bind sample_fifo sfifo_chk #(.PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd     (cmd_q),
  .empty   (fifo_empty),
  .afull   (fifo_afull),
  .full    (fifo_full),
  .ovf     (fifo_ovf),
  .unf     (fifo_unf),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr),
  .reg_rd  (reg_rd),
  .reg_sel (reg_sel)
);

// File: tb/tb_sample_fifo.sv
`timescale 1ns/1ps
module tb_sample_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        fifo_empty, fifo_afull, fifo_full, fifo_ovf, fifo_unf;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [11:0] m_mem [4];
  int          m_cnt, m_wp, m_rp;
  bit          m_ovf, m_unf;
  logic [11:0] m_last;
  logic [1:0]  m_cmd;

  always #5 clk = ~clk;

  sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_empty(fifo_empty), .fifo_afull(fifo_afull),
    .fifo_full(fifo_full), .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] exp_rdata(input logic [1:0] sel);
    logic [11:0] v;
    v = '0;
    case (sel)
      2'd0: v = (m_cnt == 0 || m_unf) ? m_last : m_mem[m_rp];
      2'd1: v = {7'd0, m_ovf, m_unf, m_cnt == 4, m_cnt == 3, m_cnt == 0};
      2'd2: v = {10'd0, m_cmd};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_step(input bit sv, input logic [11:0] sd, input bit wr,
                            input bit rd, input logic [1:0] sel, input logic [11:0] wd);
    bit conv, dum, pushed, popped;
    logic [11:0] pd;
    conv = sv && (m_cmd == 2'd1);
    dum  = wr && (sel == 2'd0);
    pd   = conv ? sd : wd;
    pushed = 1'b0;
    popped = 1'b0;
    if (m_cmd == 2'd3) begin
      m_cnt = 0; m_wp = 0; m_rp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    end else begin
      if (rd && sel == 2'd0) begin
        if (m_cnt == 0 || m_unf) m_unf = 1'b1;
        else begin
          m_last = m_mem[m_rp];
          m_rp   = (m_rp + 1) % 4;
          popped = 1'b1;
        end
      end
      if ((conv || dum) && !m_ovf) begin
        if (m_cnt == 4) m_ovf = 1'b1;
        else begin
          m_mem[m_wp] = pd;
          m_wp   = (m_wp + 1) % 4;
          pushed = 1'b1;
        end
      end
      m_cnt = m_cnt + int'(pushed) - int'(popped);
    end
    if (wr && sel == 2'd2) m_cmd = wd[1:0];
  endtask

  // One clock of stimulus: read data is checked before the edge, status after it.
  task automatic cyc(input string tag, input bit sv, input logic [11:0] sd, input bit wr,
                     input bit rd, input logic [1:0] sel, input logic [11:0] wd);
    @(negedge clk);
    smp_valid = sv; smp_data = sd; reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    #2;
    check(tag, reg_rdata, exp_rdata(sel));
    @(posedge clk);
    model_step(sv, sd, wr, rd, sel, wd);
    #2;
    check(tag, {7'd0, fifo_ovf, fifo_unf, fifo_full, fifo_afull, fifo_empty},
          {7'd0, m_ovf, m_unf, m_cnt == 4, m_cnt == 3, m_cnt == 0});
  endtask

  task automatic set_cmd(input string tag, input logic [1:0] c);
    cyc(tag, 1'b0, '0, 1'b1, 1'b0, 2'd2, {10'd0, c});
  endtask

  task automatic do_flush(input string tag, input logic [1:0] after);
    set_cmd(tag, 2'd3);
    cyc(tag, 1'b0, '0, 1'b0, 1'b1, 2'd1, '0);
    cyc(tag, 1'b0, '0, 1'b0, 1'b1, 2'd1, '0);
    set_cmd(tag, after);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    m_cnt = 0; m_wp = 0; m_rp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    m_last = '0; m_cmd = 2'd0;
    for (int i = 0; i < 4; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    cyc("R1", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    cyc("R1", 1'b0, '0, 1'b0, 1'b0, 2'd0, '0);
    cyc("R1", 1'b0, '0, 1'b0, 1'b0, 2'd2, '0);

    // R8: converter ignored while disabled
    cyc("R8", 1'b1, 12'h111, 1'b0, 1'b0, 2'd1, '0);
    // R7: reserved code 2 behaves as disable, and reads back
    set_cmd("R7", 2'd2);
    cyc("R7", 1'b1, 12'h222, 1'b0, 1'b0, 2'd2, '0);
    cyc("R7", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    // R3: fill to full under enable, checking flags at every level
    set_cmd("R7", 2'd1);
    cyc("R3", 1'b1, 12'hA01, 1'b0, 1'b0, 2'd1, '0);
    cyc("R3", 1'b1, 12'hA02, 1'b0, 1'b0, 2'd1, '0);
    cyc("R3", 1'b1, 12'hA03, 1'b0, 1'b0, 2'd1, '0);
    cyc("R3", 1'b1, 12'hA04, 1'b0, 1'b0, 2'd1, '0);
    // R4: overflow, then a pop does not reopen the write side
    cyc("R4", 1'b1, 12'hBAD, 1'b0, 1'b0, 2'd1, '0);
    cyc("R4", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R4", 1'b1, 12'hBEE, 1'b0, 1'b0, 2'd1, '0);
    cyc("R4", 1'b0, '0, 1'b1, 1'b0, 2'd0, 12'hBEF);
    // R2: remaining samples oldest first
    cyc("R2", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R2", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R2", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    // R5: read while empty replays the last sample and sets underflow
    cyc("R5", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R5", 1'b0, '0, 1'b1, 1'b0, 2'd0, 12'h5A5);
    cyc("R5", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R5", 1'b0, '0, 1'b0, 1'b0, 2'd0, '0);
    // R6: flags stay until flush, flush clears everything
    cyc("R6", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    do_flush("R6", 2'd0);
    cyc("R6", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    // R9: dummy push while disabled; converter wins a shared cycle
    cyc("R9", 1'b0, '0, 1'b1, 1'b0, 2'd0, 12'h0D1);
    set_cmd("R9", 2'd1);
    cyc("R9", 1'b1, 12'hC01, 1'b1, 1'b0, 2'd0, 12'h0D2);
    cyc("R9", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R9", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    cyc("R9", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    // R9: dummy write ignored during flush
    set_cmd("R9", 2'd3);
    cyc("R9", 1'b0, '0, 1'b1, 1'b0, 2'd0, 12'h0D3);
    cyc("R9", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    set_cmd("R9", 2'd0);
    cyc("R9", 1'b0, '0, 1'b0, 1'b0, 2'd1, '0);
    // R10: select 3 reads zero and a read there does not pop
    cyc("R10", 1'b0, '0, 1'b1, 1'b0, 2'd0, 12'h777);
    cyc("R10", 1'b0, '0, 1'b0, 1'b1, 2'd3, '0);
    cyc("R10", 1'b0, '0, 1'b0, 1'b1, 2'd1, '0);
    cyc("R10", 1'b0, '0, 1'b0, 1'b1, 2'd0, '0);
    do_flush("R6", 2'd1);

    // R2: phased pseudo-random sweep against the model
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      bit sv, wr, rd;
      logic [1:0] sel;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[13:9] == 5'd0) begin
        set_cmd("R7", lf[1:0]);
      end else begin
        if (((i / 300) % 2) == 0) begin
          sv = lf[0] | lf[1];
          rd = lf[2] & lf[3];
        end else begin
          sv = lf[0] & lf[1];
          rd = lf[2] | lf[3];
        end
        wr  = lf[4] & lf[5] & lf[6];
        sel = (lf[8:7] == 2'd3) ? 2'd1 : 2'd0;
        cyc("R2", sv, lf[11:0] ^ 12'h3C3, wr, rd, sel, {lf[3:0], lf[15:8]});
      end
      if ((i % 97) == 96) do_flush("R6", 2'd1);
    end
    finish_run();
  end
endmodule